// File: doc/BRIEF.md
# Stop-Hold-Recover Safety Sequencer

This block decides how a servo axis moves between normal motion, limited motion, a proven stopped condition and a controlled restart. Fault classification happens upstream. The sequencer receives two vectors: a hard-fault vector (overcurrent, critical overtemperature, watchdog expiry, emergency stop, travel limit, brake disagreement) and a soft-warning vector (bounded encoder anomaly, temperature margin, plausibility warning). Any bit of the hard vector means a stop is required. Any bit of the soft vector means motion is allowed only in a limited mode. The sequencer drives the torque-off command and the brake-engage command, and it reads back the torque-off status and the brake feedback.

A stop counts as complete only when both feedbacks confirm it. A restart is allowed only after an external gate agrees. The restart then steps through a verify, brake-release, torque-enable and observe sequence, and it checks the feedback at every step. Three timeout inputs are programmed in clock cycles: the longest stay in limited mode, the brake or torque confirmation window, and the observe window. A sticky fault flag records a stop that could not be proven. Each state change produces a one-cycle record that holds the old state, the new state, a reason code and a cycle timestamp.

Top module: `safe_motion_sequencer`

## Requirements
- R1: State codes are RUN=0, DEGRADED=1, SAFE_STOP=2, HOLD=3, RECOVER=4. In RUN, the outputs are sto_cmd=0, brake_cmd=0 and limit_en=0. A nonzero hard_flt moves the machine to SAFE_STOP on the next cycle. Otherwise a nonzero soft_warn moves it to DEGRADED.
- R2: In DEGRADED, limit_en=1. The machine returns to RUN after cfg_observe_cycles consecutive sampled cycles with soft_warn equal to zero. A warning during the count restarts it.
- R3: DEGRADED escalates to SAFE_STOP on a hard fault (reason 1), which takes priority. It also escalates after cfg_degrade_cycles cycles spent in the state (reason 3).
- R4: SAFE_STOP and HOLD drive sto_cmd=1 and brake_cmd=1. SAFE_STOP moves to HOLD (reason 5) only in a cycle where sto_active=1 and brake_engaged=1. Hard faults seen during SAFE_STOP do not change its behaviour.
- R5: If SAFE_STOP lasts cfg_brake_cycles cycles without that confirmation, fault_latched becomes 1 and the state stays SAFE_STOP.
- R6: In HOLD, a cycle with sto_active=0 or brake_engaged=0 sets fault_latched and keeps HOLD. HOLD goes to RECOVER (reason 6) only when gate_ok=1, hard_flt is zero and both feedbacks are consistent. HOLD never goes anywhere else.
- R7: RECOVER runs four steps in order. (a) Verify, one cycle: sto=1, brake=1. If no warning and both feedbacks are still engaged, fault_latched is cleared. (b) Release: sto=1, brake=0, until brake_engaged=0. (c) Torque enable: sto=0, brake=0, until sto_active=0. (d) Observe: sto=0, brake=0, for cfg_observe_cycles cycles. The machine then goes to RUN (reason 8). Steps (b) and (c) each fail after cfg_brake_cycles cycles.
- R8: In RECOVER, a hard fault goes to SAFE_STOP with reason 1. Any feedback mismatch, a step timeout, a soft warning at verify or observe, or observe_ok=0 during observe goes to SAFE_STOP with reason 7.
- R9: A state change makes rec_valid=1 for one cycle together with rec_prev, rec_next and rec_reason. Reason codes: 1 hard, 2 soft, 3 degrade timeout, 4 cleared, 5 stop proven, 6 gate, 7 recovery failure, 8 observed, 9 illegal state. rec_time is the cycle count since reset release, counted from 0 in the first cycle, and is taken in the last cycle of the old state.
- R10: While rst=1 the block holds SAFE_STOP with sto_cmd=1, brake_cmd=1, limit_en=0, fault_latched=0 and rec_valid=0. An illegal state code forces SAFE_STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hard_flt | input | HARD_W | Hard-fault vector; any bit requests a stop |
| soft_warn | input | SOFT_W | Soft-warning vector; any bit requests limited motion |
| sto_active | input | 1 | Torque-off status feedback |
| brake_engaged | input | 1 | Brake feedback, 1 = engaged |
| gate_ok | input | 1 | External restart permission |
| observe_ok | input | 1 | Health indication during the observe step |
| cfg_degrade_cycles | input | TMR_W | Longest stay in DEGRADED |
| cfg_brake_cycles | input | TMR_W | Confirmation window for brake and torque steps |
| cfg_observe_cycles | input | TMR_W | Clear window and observe window length |
| sto_cmd | output | 1 | Torque-off / inhibit command |
| brake_cmd | output | 1 | Brake engage command |
| limit_en | output | 1 | Torque/speed limit enable |
| fault_latched | output | 1 | Sticky unproven-stop flag |
| state_o | output | 3 | Current state code |
| rec_valid | output | 1 | One-cycle transition strobe |
| rec_prev | output | 3 | State before the transition |
| rec_next | output | 3 | State after the transition |
| rec_reason | output | 4 | Reason code |
| rec_time | output | STAMP_W | Cycle timestamp of the transition |

## Verification
Every output is registered from the same clock edge that samples the inputs. A change in the fault vectors or feedbacks therefore shows in the state, the commands, the latch and the record exactly one cycle later. Timeouts show after the programmed number of cycles, counted from the cycle of entry. The bench model advances on the rising edge from the same input values and compares every output at the following falling edge. The directed checks count falling edges spent in a state, so a window that ends one cycle early or late is caught.

// File: rtl/safe_seq_pkg.sv
package safe_seq_pkg;

  typedef enum logic [2:0] {
    ST_RUN       = 3'd0,
    ST_DEGRADED  = 3'd1,
    ST_SAFE_STOP = 3'd2,
    ST_HOLD      = 3'd3,
    ST_RECOVER   = 3'd4
  } seq_state_e;

  typedef enum logic [1:0] {
    PH_VERIFY  = 2'd0,
    PH_RELEASE = 2'd1,
    PH_TORQUE  = 2'd2,
    PH_OBSERVE = 2'd3
  } rec_phase_e;

  typedef enum logic [3:0] {
    RC_NONE         = 4'd0,
    RC_HARD         = 4'd1,
    RC_SOFT         = 4'd2,
    RC_DEG_TIMEOUT  = 4'd3,
    RC_CLEARED      = 4'd4,
    RC_STOPPED      = 4'd5,
    RC_GATE         = 4'd6,
    RC_RECOVER_FAIL = 4'd7,
    RC_OBSERVED     = 4'd8,
    RC_ILLEGAL      = 4'd9
  } reason_e;

  typedef struct packed {
    logic sto;
    logic brake;
    logic limit;
  } drive_t;

  // Command pattern for a given state and recovery step
  function automatic drive_t drive_of(seq_state_e s, rec_phase_e p);
    drive_t d;
    d = '{sto: 1'b1, brake: 1'b1, limit: 1'b0};
    case (s)
      ST_RUN:      d = '{sto: 1'b0, brake: 1'b0, limit: 1'b0};
      ST_DEGRADED: d = '{sto: 1'b0, brake: 1'b0, limit: 1'b1};
      ST_RECOVER: begin
        case (p)
          PH_VERIFY:  d = '{sto: 1'b1, brake: 1'b1, limit: 1'b0};
          PH_RELEASE: d = '{sto: 1'b1, brake: 1'b0, limit: 1'b0};
          default:    d = '{sto: 1'b0, brake: 1'b0, limit: 1'b0};
        endcase
      end
      default:     d = '{sto: 1'b1, brake: 1'b1, limit: 1'b0};
    endcase
    return d;
  endfunction

endpackage

// File: rtl/safe_seq_counter.sv
module safe_seq_counter #(
  parameter int W    = 16,
  parameter bit WRAP = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         en,
  output logic [W-1:0] q
);

  localparam logic [W-1:0] ONE = W'(1);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  generate
    if (WRAP) begin : g_wrap
      always_ff @(posedge clk) begin
        if (rst || clr) q <= '0;
        else if (en)    q <= q + ONE;
      end
    end else begin : g_sat
      always_ff @(posedge clk) begin
        if (rst || clr)          q <= '0;
        else if (en && q != TOP) q <= q + ONE;
      end

      // saturating timer must never wrap, or a timeout would be missed (R5)
      p_timer_no_wrap_r5: assert property (@(posedge clk) disable iff (rst)
        (!clr && q == TOP) |=> (q == TOP || $past(clr) || rst));
    end
  endgenerate

endmodule

// File: rtl/safe_seq_next.sv
module safe_seq_next
  import safe_seq_pkg::*;
#(
  parameter int TMR_W = 16
) (
  input  seq_state_e       state,
  input  rec_phase_e       phase,
  input  logic [TMR_W-1:0] dwell,
  input  logic [TMR_W-1:0] clear_run,
  input  logic             hard_any,
  input  logic             soft_any,
  input  logic             sto_active,
  input  logic             brake_engaged,
  input  logic             gate_ok,
  input  logic             observe_ok,
  input  logic [TMR_W-1:0] cfg_degrade_cycles,
  input  logic [TMR_W-1:0] cfg_brake_cycles,
  input  logic [TMR_W-1:0] cfg_observe_cycles,
  output seq_state_e       nxt_state,
  output rec_phase_e       nxt_phase,
  output reason_e          reason,
  output logic             latch_set,
  output logic             latch_clr
);

  localparam logic [TMR_W:0] ONE_X = (TMR_W+1)'(1);

  logic [TMR_W:0] dwell_n;
  logic [TMR_W:0] clear_n;
  logic           deg_due, brake_due, obs_due, clear_due, stopped;

  // cycles spent including the present one
  assign dwell_n   = {1'b0, dwell} + ONE_X;
  assign clear_n   = {1'b0, clear_run} + ONE_X;
  assign deg_due   = dwell_n >= {1'b0, cfg_degrade_cycles};
  assign brake_due = dwell_n >= {1'b0, cfg_brake_cycles};
  assign obs_due   = dwell_n >= {1'b0, cfg_observe_cycles};
  assign clear_due = clear_n >= {1'b0, cfg_observe_cycles};
  assign stopped   = sto_active && brake_engaged;

  always_comb begin
    nxt_state = state;
    nxt_phase = phase;
    reason    = RC_NONE;
    latch_set = 1'b0;
    latch_clr = 1'b0;
    case (state)
      ST_RUN: begin
        if (hard_any) begin
          nxt_state = ST_SAFE_STOP; reason = RC_HARD;
        end else if (soft_any) begin
          nxt_state = ST_DEGRADED;  reason = RC_SOFT;
        end
      end
      ST_DEGRADED: begin
        if (hard_any) begin
          nxt_state = ST_SAFE_STOP; reason = RC_HARD;
        end else if (deg_due) begin
          nxt_state = ST_SAFE_STOP; reason = RC_DEG_TIMEOUT;
        end else if (!soft_any && clear_due) begin
          nxt_state = ST_RUN;       reason = RC_CLEARED;
        end
      end
      ST_SAFE_STOP: begin
        if (stopped) begin
          nxt_state = ST_HOLD; reason = RC_STOPPED;
        end else if (brake_due) begin
          latch_set = 1'b1;
        end
      end
      ST_HOLD: begin
        if (!stopped) begin
          latch_set = 1'b1;
        end else if (gate_ok && !hard_any) begin
          nxt_state = ST_RECOVER; reason = RC_GATE;
        end
      end
      ST_RECOVER: begin
        if (hard_any) begin
          nxt_state = ST_SAFE_STOP; reason = RC_HARD;
        end else begin
          case (phase)
            PH_VERIFY: begin
              if (soft_any || !stopped) begin
                nxt_state = ST_SAFE_STOP; reason = RC_RECOVER_FAIL;
              end else begin
                latch_clr = 1'b1;
                nxt_phase = PH_RELEASE;
              end
            end
            PH_RELEASE: begin
              if (!sto_active) begin
                nxt_state = ST_SAFE_STOP; reason = RC_RECOVER_FAIL;
              end else if (!brake_engaged) begin
                nxt_phase = PH_TORQUE;
              end else if (brake_due) begin
                nxt_state = ST_SAFE_STOP; reason = RC_RECOVER_FAIL;
              end
            end
            PH_TORQUE: begin
              if (brake_engaged) begin
                nxt_state = ST_SAFE_STOP; reason = RC_RECOVER_FAIL;
              end else if (!sto_active) begin
                nxt_phase = PH_OBSERVE;
              end else if (brake_due) begin
                nxt_state = ST_SAFE_STOP; reason = RC_RECOVER_FAIL;
              end
            end
            default: begin
              if (brake_engaged || sto_active || !observe_ok || soft_any) begin
                nxt_state = ST_SAFE_STOP; reason = RC_RECOVER_FAIL;
              end else if (obs_due) begin
                nxt_state = ST_RUN; reason = RC_OBSERVED;
              end
            end
          endcase
        end
      end
      default: begin
        nxt_state = ST_SAFE_STOP; reason = RC_ILLEGAL;
      end
    endcase
    if (nxt_state != ST_RECOVER) nxt_phase = PH_VERIFY;
  end

endmodule

// File: rtl/safe_seq_record.sv
module safe_seq_record
  import safe_seq_pkg::*;
#(
  parameter int STAMP_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  seq_state_e         cur_state,
  input  seq_state_e         nxt_state,
  input  reason_e            cause,
  input  logic [STAMP_W-1:0] stamp,
  output logic               rec_valid,
  output logic [2:0]         rec_prev,
  output logic [2:0]         rec_next,
  output logic [3:0]         rec_reason,
  output logic [STAMP_W-1:0] rec_time
);

  always_ff @(posedge clk) begin
    if (rst) begin
      rec_valid  <= 1'b0;
      rec_prev   <= '0;
      rec_next   <= '0;
      rec_reason <= '0;
      rec_time   <= '0;
    end else if (nxt_state != cur_state) begin
      rec_valid  <= 1'b1;
      rec_prev   <= cur_state;
      rec_next   <= nxt_state;
      rec_reason <= cause;
      rec_time   <= stamp;
    end else begin
      rec_valid  <= 1'b0;
    end
  end

  // a strobe always carries a cause (R9)
  p_rec_has_reason_r9: assert property (@(posedge clk) disable iff (rst)
    rec_valid |-> rec_reason != 4'd0);

endmodule

// File: rtl/safe_motion_sequencer.sv
module safe_motion_sequencer
  import safe_seq_pkg::*;
#(
  parameter int HARD_W  = 6,
  parameter int SOFT_W  = 3,
  parameter int TMR_W   = 16,
  parameter int STAMP_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [HARD_W-1:0]  hard_flt,
  input  logic [SOFT_W-1:0]  soft_warn,
  input  logic               sto_active,
  input  logic               brake_engaged,
  input  logic               gate_ok,
  input  logic               observe_ok,
  input  logic [TMR_W-1:0]   cfg_degrade_cycles,
  input  logic [TMR_W-1:0]   cfg_brake_cycles,
  input  logic [TMR_W-1:0]   cfg_observe_cycles,
  output logic               sto_cmd,
  output logic               brake_cmd,
  output logic               limit_en,
  output logic               fault_latched,
  output logic [2:0]         state_o,
  output logic               rec_valid,
  output logic [2:0]         rec_prev,
  output logic [2:0]         rec_next,
  output logic [3:0]         rec_reason,
  output logic [STAMP_W-1:0] rec_time
);

  seq_state_e         state, nxt_state;
  rec_phase_e         phase, nxt_phase;
  reason_e            reason;
  logic               latch_set, latch_clr;
  logic               hard_any, soft_any;
  logic [TMR_W-1:0]   dwell, clear_run;
  logic [STAMP_W-1:0] stamp;
  logic               dwell_clr, clear_clr;
  drive_t             drv_nxt;

  assign hard_any = |hard_flt;
  assign soft_any = |soft_warn;

  safe_seq_next #(.TMR_W(TMR_W)) u_next (
    .state              (state),
    .phase              (phase),
    .dwell              (dwell),
    .clear_run          (clear_run),
    .hard_any           (hard_any),
    .soft_any           (soft_any),
    .sto_active         (sto_active),
    .brake_engaged      (brake_engaged),
    .gate_ok            (gate_ok),
    .observe_ok         (observe_ok),
    .cfg_degrade_cycles (cfg_degrade_cycles),
    .cfg_brake_cycles   (cfg_brake_cycles),
    .cfg_observe_cycles (cfg_observe_cycles),
    .nxt_state          (nxt_state),
    .nxt_phase          (nxt_phase),
    .reason             (reason),
    .latch_set          (latch_set),
    .latch_clr          (latch_clr)
  );

  // dwell restarts on every state or recovery-step change
  assign dwell_clr = (nxt_state != state) || (nxt_phase != phase);

  safe_seq_counter #(.W(TMR_W), .WRAP(1'b0)) u_dwell (
    .clk (clk), .rst (rst), .clr (dwell_clr), .en (1'b1), .q (dwell)
  );

  // consecutive warning-free cycles while limited
  assign clear_clr = (state != ST_DEGRADED) || (nxt_state != ST_DEGRADED) || soft_any;

  safe_seq_counter #(.W(TMR_W), .WRAP(1'b0)) u_clear (
    .clk (clk), .rst (rst), .clr (clear_clr), .en (1'b1), .q (clear_run)
  );

  safe_seq_counter #(.W(STAMP_W), .WRAP(1'b1)) u_stamp (
    .clk (clk), .rst (rst), .clr (1'b0), .en (1'b1), .q (stamp)
  );

  assign drv_nxt = drive_of(nxt_state, nxt_phase);

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_SAFE_STOP;
      phase         <= PH_VERIFY;
      fault_latched <= 1'b0;
      sto_cmd       <= 1'b1;
      brake_cmd     <= 1'b1;
      limit_en      <= 1'b0;
    end else begin
      state     <= nxt_state;
      phase     <= nxt_phase;
      sto_cmd   <= drv_nxt.sto;
      brake_cmd <= drv_nxt.brake;
      limit_en  <= drv_nxt.limit;
      if (latch_set)      fault_latched <= 1'b1;
      else if (latch_clr) fault_latched <= 1'b0;
    end
  end

  assign state_o = state;

  safe_seq_record #(.STAMP_W(STAMP_W)) u_record (
    .clk        (clk),
    .rst        (rst),
    .cur_state  (state),
    .nxt_state  (nxt_state),
    .cause      (reason),
    .stamp      (stamp),
    .rec_valid  (rec_valid),
    .rec_prev   (rec_prev),
    .rec_next   (rec_next),
    .rec_reason (rec_reason),
    .rec_time   (rec_time)
  );

  p_run_hard_stop_r1: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN && hard_any) |=> state == ST_SAFE_STOP);

  p_degraded_limits_r2: assert property (@(posedge clk) disable iff (rst)
    state == ST_DEGRADED |-> limit_en);

  p_deg_hard_escalate_r3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DEGRADED && hard_any) |=> state == ST_SAFE_STOP);

  p_stop_commands_r4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SAFE_STOP || state == ST_HOLD) |-> (sto_cmd && brake_cmd));

  p_hold_needs_proof_r4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SAFE_STOP && !(sto_active && brake_engaged)) |=> state != ST_HOLD);

  p_unproven_stays_r5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SAFE_STOP && !(sto_active && brake_engaged)) |=> state == ST_SAFE_STOP);

  p_hold_exits_r6: assert property (@(posedge clk) disable iff (rst)
    state == ST_HOLD |=> (state == ST_HOLD || state == ST_RECOVER));

  p_hold_mismatch_latch_r6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HOLD && !(sto_active && brake_engaged)) |=> fault_latched);

  p_recover_hard_r8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RECOVER && hard_any) |=> state == ST_SAFE_STOP);

  p_record_matches_r9: assert property (@(posedge clk) disable iff (rst)
    rec_valid |-> (rec_next == state_o && rec_prev != rec_next));

  p_legal_state_r10: assert property (@(posedge clk) disable iff (rst)
    state_o <= 3'd4);

endmodule

// File: tb/tb_safe_motion_sequencer.sv
module tb_safe_motion_sequencer;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  hard_flt = '0;
  logic [2:0]  soft_warn = '0;
  logic        sto_active = 1'b1;
  logic        brake_engaged = 1'b1;
  logic        gate_ok = 1'b0;
  logic        observe_ok = 1'b1;
  logic [15:0] cfg_deg = 16'd8;
  logic [15:0] cfg_brk = 16'd5;
  logic [15:0] cfg_obs = 16'd4;
  logic        sto_cmd, brake_cmd, limit_en, fault_latched, rec_valid;
  logic [2:0]  state_o, rec_prev, rec_next;
  logic [3:0]  rec_reason;
  logic [31:0] rec_time;

  always #5 clk = ~clk;

  safe_motion_sequencer dut (
    .clk(clk), .rst(rst), .hard_flt(hard_flt), .soft_warn(soft_warn),
    .sto_active(sto_active), .brake_engaged(brake_engaged),
    .gate_ok(gate_ok), .observe_ok(observe_ok),
    .cfg_degrade_cycles(cfg_deg), .cfg_brake_cycles(cfg_brk),
    .cfg_observe_cycles(cfg_obs),
    .sto_cmd(sto_cmd), .brake_cmd(brake_cmd), .limit_en(limit_en),
    .fault_latched(fault_latched), .state_o(state_o), .rec_valid(rec_valid),
    .rec_prev(rec_prev), .rec_next(rec_next), .rec_reason(rec_reason),
    .rec_time(rec_time)
  );

  int n_checks = 0;
  int n_bad = 0;
  int cycles = 0;
  bit done = 0;

  task automatic chk(string tag, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // plant: feedback follows command unless the brake is forced
  bit stuck_on = 0;
  bit stuck_val = 0;
  always @(negedge clk) begin
    brake_engaged <= stuck_on ? stuck_val : brake_cmd;
    sto_active    <= sto_cmd;
  end

  // behavioural reference: 0 run,1 limited,2 stopping,3 hold,4 restart
  int m_st, m_ph, m_tmr, m_clr, m_ts, m_ns, m_nph, m_rsn;
  bit m_latch, m_rv, m_lset, m_lclr, m_hard, m_soft, m_stop;
  int m_prev, m_next, m_reason, m_time;

  always @(posedge clk) begin
    if (rst) begin
      m_st = 2; m_ph = 0; m_tmr = 0; m_clr = 0; m_latch = 0; m_ts = 0; m_rv = 0;
    end else begin
      m_hard = |hard_flt; m_soft = |soft_warn;
      m_stop = sto_active && brake_engaged;
      m_ns = m_st; m_nph = m_ph; m_rsn = 0; m_lset = 0; m_lclr = 0;
      if (m_st == 0) begin
        if (m_hard) begin m_ns = 2; m_rsn = 1; end
        else if (m_soft) begin m_ns = 1; m_rsn = 2; end
      end else if (m_st == 1) begin
        if (m_hard) begin m_ns = 2; m_rsn = 1; end
        else if (m_tmr + 1 >= cfg_deg) begin m_ns = 2; m_rsn = 3; end
        else if (!m_soft && m_clr + 1 >= cfg_obs) begin m_ns = 0; m_rsn = 4; end
      end else if (m_st == 2) begin
        if (m_stop) begin m_ns = 3; m_rsn = 5; end
        else if (m_tmr + 1 >= cfg_brk) m_lset = 1;
      end else if (m_st == 3) begin
        if (!m_stop) m_lset = 1;
        else if (gate_ok && !m_hard) begin m_ns = 4; m_rsn = 6; end
      end else begin
        if (m_hard) begin m_ns = 2; m_rsn = 1; end
        else if (m_ph == 0) begin
          if (m_soft || !m_stop) begin m_ns = 2; m_rsn = 7; end
          else begin m_lclr = 1; m_nph = 1; end
        end else if (m_ph == 1) begin
          if (!sto_active) begin m_ns = 2; m_rsn = 7; end
          else if (!brake_engaged) m_nph = 2;
          else if (m_tmr + 1 >= cfg_brk) begin m_ns = 2; m_rsn = 7; end
        end else if (m_ph == 2) begin
          if (brake_engaged) begin m_ns = 2; m_rsn = 7; end
          else if (!sto_active) m_nph = 3;
          else if (m_tmr + 1 >= cfg_brk) begin m_ns = 2; m_rsn = 7; end
        end else begin
          if (brake_engaged || sto_active || !observe_ok || m_soft) begin m_ns = 2; m_rsn = 7; end
          else if (m_tmr + 1 >= cfg_obs) begin m_ns = 0; m_rsn = 8; end
        end
      end
      if (m_ns != 4) m_nph = 0;
      if (m_lset) m_latch = 1; else if (m_lclr) m_latch = 0;
      if (m_st != 1 || m_ns != 1 || m_soft) m_clr = 0; else m_clr++;
      if (m_ns != m_st || m_nph != m_ph) m_tmr = 0; else if (m_tmr < 65535) m_tmr++;
      m_rv = (m_ns != m_st);
      if (m_rv) begin m_prev = m_st; m_next = m_ns; m_reason = m_rsn; m_time = m_ts; end
      m_ts++;
      m_st = m_ns; m_ph = m_nph;
    end
  end

  function automatic int exp_sto(int s, int p);
    if (s == 0 || s == 1) return 0;
    if (s == 4) return (p <= 1) ? 1 : 0;
    return 1;
  endfunction

  function automatic int exp_brk(int s, int p);
    if (s == 0 || s == 1) return 0;
    if (s == 4) return (p == 0) ? 1 : 0;
    return 1;
  endfunction

  // compare every output against the model each cycle
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R1 state", state_o, m_st);
      chk("R4 sto_cmd", sto_cmd, exp_sto(m_st, m_ph));
      chk("R7 brake_cmd", brake_cmd, exp_brk(m_st, m_ph));
      chk("R2 limit_en", limit_en, (m_st == 1) ? 1 : 0);
      chk("R5 fault_latched", fault_latched, m_latch);
      chk("R9 rec_valid", rec_valid, m_rv);
      if (m_rv) begin
        chk("R9 rec_prev", rec_prev, m_prev);
        chk("R9 rec_next", rec_next, m_next);
        chk("R9 rec_reason", rec_reason, m_reason);
        chk("R9 rec_time", rec_time, m_time);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000 && !done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=0", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_bad);
      $finish;
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_state(int s, int lim);
    for (int i = 0; i < lim && state_o != s; i++) cyc(1);
  endtask

  task automatic restart_to_run();
    wait_state(3, 20);
    gate_ok = 1; cyc(1); gate_ok = 0;
    wait_state(0, 40);
  endtask

  initial begin
    int k;
    cyc(3);
    // R10: reset state
    chk("R10 reset state", state_o, 2);
    chk("R10 reset sto", sto_cmd, 1);
    chk("R10 reset brake", brake_cmd, 1);
    chk("R10 reset latch", fault_latched, 0);
    chk("R10 reset rec_valid", rec_valid, 0);
    rst = 0;
    cyc(3);
    chk("R4 proven stop reaches hold", state_o, 3);

    // R6: feedback glitch in hold
    stuck_on = 1; stuck_val = 0; cyc(2); stuck_on = 0; cyc(2);
    chk("R6 latch after hold mismatch", fault_latched, 1);
    chk("R6 still hold", state_o, 3);

    // R7: gated restart
    restart_to_run();
    chk("R7 restart ends in run", state_o, 0);
    chk("R7 latch cleared", fault_latched, 0);

    // R1 / R2: warning, then clear window
    soft_warn = 3'b010; cyc(2);
    chk("R1 warning enters degraded", state_o, 1);
    chk("R2 limit asserted", limit_en, 1);
    soft_warn = 0; cyc(3);
    chk("R2 still degraded in window", state_o, 1);
    cyc(1);
    chk("R2 back to run", state_o, 0);

    // R3: degrade timeout
    soft_warn = 3'b001;
    wait_state(1, 5);
    k = 0;
    while (state_o == 1 && k < 50) begin k++; cyc(1); end
    chk("R3 degrade dwell cycles", k, 8);
    chk("R3 timeout reason", rec_reason, 3);
    soft_warn = 0;
    restart_to_run();

    // R1 / R9: hard fault from run
    hard_flt = 6'b000100; cyc(1);
    chk("R1 hard fault stops", state_o, 2);
    chk("R9 strobe", rec_valid, 1);
    chk("R9 prev", rec_prev, 0);
    chk("R9 reason hard", rec_reason, 1);
    hard_flt = 0;
    restart_to_run();

    // R3: hard beats pending warning
    soft_warn = 3'b100; cyc(2);
    hard_flt = 6'b100000; cyc(1);
    chk("R3 hard in degraded", state_o, 2);
    chk("R3 hard reason", rec_reason, 1);
    hard_flt = 0; soft_warn = 0;

    // R8: observe failure
    wait_state(3, 20);
    gate_ok = 1; cyc(1); gate_ok = 0; observe_ok = 0;
    wait_state(2, 30);
    chk("R8 failed restart stops", state_o, 2);
    chk("R8 reason", rec_reason, 7);
    chk("R8 prev restart", rec_prev, 4);
    observe_ok = 1;
    restart_to_run();

    // R5: brake never confirms
    stuck_on = 1; stuck_val = 0; cyc(1);
    hard_flt = 6'b000001; cyc(1); hard_flt = 0;
    chk("R5 stopping", state_o, 2);
    cyc(4);
    chk("R5 latch not early", fault_latched, 0);
    cyc(1);
    chk("R5 latch at timeout", fault_latched, 1);
    chk("R5 stays stopped", state_o, 2);
    stuck_on = 0;

    // R7: reprogrammed observe window
    cfg_obs = 16'd2; cfg_deg = 16'd3;
    restart_to_run();
    chk("R7 run with short window", state_o, 0);
    soft_warn = 3'b001;
    wait_state(2, 10);
    chk("R3 short degrade timeout", rec_reason, 3);
    soft_warn = 0;
    restart_to_run();

    // R10: reset mid-motion
    soft_warn = 3'b001; cyc(1);
    rst = 1; cyc(2);
    chk("R10 reset forces stop", state_o, 2);
    chk("R10 reset clears limit", limit_en, 0);
    soft_warn = 0; rst = 0; cyc(4);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_bad);
    $finish;
  end

endmodule